// File: doc/BRIEF.md
# Cascaded Walking-Ones Sequencer

This block strings together a parameterised number of decade stages so that one active position walks across all of them, one step per clock. Each stage is a five-bit Johnson ring with ten decoded states. The first stage steps from 0 to 9 and then stops there. Every later stage is only allowed to step on clocks where its left neighbour is sitting on 9, and it stops on its own 9. The clock gating of a discrete build is modelled as a per-stage enable. All flops share one clock.

When the final stage reaches 9, the first stage is cleared on the next edge. It is held at 0 for as long as the final stage stays at 9. After that the clear travels rightward one stage per clock: each stage is cleared while its left neighbour reads 0. A full cycle for N stages takes 10N clocks. The first 9N+1 of those clocks are distinct walking positions. The remaining N-1 are the clear sweep, during which the final position is held.

An active-low power-on reset forces every stage to 0 at once. All outputs here are plain status pins. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `walk_chain`

## Requirements
- R1: While `rst_n` is low, asynchronously and regardless of the clock, every stage reads count 0, `pos_hot` has only bit 0 set, and `seq_done` is low.
- R2: Stage 0 steps by one per clock from 0 up to 9, then stays at 9 until it is cleared.
- R3: A stage k≥1 changes count only on a clock where stage k-1 reads 9 (stepping) or reads 0 (clearing). On any other clock it holds its count.
- R4: Every stage that reads 9 keeps reading 9 until its clear input acts. No stage ever wraps from 9 to 0 by stepping.
- R5: The clock after the last stage reads 9, stage 0 reads 0. Stage 0 stays at 0 while the last stage still reads 9.
- R6: A stage k≥1 reads 0 on the clock after stage k-1 reads 0. As a result, the clear reaches the last stage N clocks after it reaches 9, and the whole pattern repeats every 10N clocks.
- R7: Stage k reports its count as unsigned binary 0..9 in `stage_cnt[4k+3:4k]`. It reports the same count as a one-hot value in `stage_hot[10k+9:10k]`, with bit 10k+c set for count c.
- R8: `pos_hot` has exactly one bit set, at index 9k+c. Here k is the highest-numbered stage with a nonzero count (k=0 if there is none) and c is that stage's count. The index therefore reads t for t = 0..9N clocks after reset, and stays at 9N during the clear sweep.
- R9: `seq_done` is high exactly while the last stage reads 9. That is N consecutive clocks out of every 10N.
- R10: Asserting `rst_n` partway through a cycle returns every output to its R1 state at once. Counting restarts from position 0 after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all stages |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| stage_hot | output | 10*NSTAGES | Concatenated one-hot decoded outputs, stage k in bits 10k+9:10k |
| stage_cnt | output | 4*NSTAGES | Concatenated binary counts, stage k in bits 4k+3:4k |
| pos_hot | output | 9*NSTAGES+1 | One-hot walking position across the chain |
| seq_done | output | 1 | High while the last stage is parked on 9 |

## Verification
The bench runs a three-stage chain for several full 10N-clock cycles. On every clock it compares each stage count, each one-hot field, the position and the done flag against closed-form values computed from the clock index.

The hand-over clocks get the closest attention. A stage that ignored its neighbour's enable would step early and jump the position ahead. A stage that ignored its own park would wrap from 9 back to 0 and restart the sweep. A clear taken from the wrong neighbour, or one that was not held, would either collapse the sweep into one clock or let stage 0 restart while the last stage is still at 9, which would shorten the period and skip `seq_done` clocks.

A reset applied mid-cycle checks that the clear is asynchronous and that counting restarts cleanly.

// File: rtl/wchain_pkg.sv
package wchain_pkg;
  localparam int DIGITS = 10;
  localparam int JW     = DIGITS / 2;
  localparam int CW     = $clog2(DIGITS);

  typedef logic [JW-1:0] jstate_t;
  typedef logic [CW-1:0] count_t;

  // Advance a twisted ring by one place.
  function automatic jstate_t jstep(jstate_t s);
    return {s[JW-2:0], ~s[JW-1]};
  endfunction

  // Map a ring pattern to its count 0..DIGITS-1.
  function automatic count_t jdecode(jstate_t s);
    int ones;
    ones = 0;
    for (int i = 0; i < JW; i++) ones += int'(s[i]);
    if (!s[JW-1]) return count_t'(ones);
    return count_t'(DIGITS - ones);
  endfunction

  // Ring pattern expected for a given count.
  function automatic jstate_t jencode(count_t c);
    jstate_t m;
    if (int'(c) <= JW) m = jstate_t'((1 << int'(c)) - 1);
    else               m = ~jstate_t'((1 << (JW - (DIGITS - int'(c)))) - 1);
    return m;
  endfunction
endpackage

// File: rtl/decade_stage.sv
module decade_stage
  import wchain_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              clr,
  output count_t            cnt,
  output logic [DIGITS-1:0] hot,
  output logic              at0,
  output logic              at9
);
  jstate_t ring;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ring <= '0;
    else if (clr)           ring <= '0;
    else if (adv && !at9)   ring <= jstep(ring);
  end

  assign at0 = !ring[JW-1] && !ring[0];
  assign at9 = ring[JW-1] && !ring[JW-2];
  assign cnt = jdecode(ring);
  assign hot = DIGITS'(1) << cnt;

  assert_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ring == jencode(cnt));
  assert_park_R4: assert property (@(posedge clk) disable iff (!rst_n)
    at9 && !clr |=> at9);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !at9 && !clr |=> cnt == $past(cnt) + count_t'(1));
endmodule

// File: rtl/pos_encoder.sv
module pos_encoder
  import wchain_pkg::*;
#(
  parameter int NST  = 3,
  localparam int POSW = (DIGITS - 1) * NST + 1
)(
  input  logic [NST*CW-1:0] cnts,
  output logic [POSW-1:0]   pos
);
  int idx;

  always_comb begin
    idx = 0;
    for (int k = 0; k < NST; k++) begin
      if (k == 0 || cnts[k*CW +: CW] != '0)
        idx = (DIGITS - 1) * k + int'(cnts[k*CW +: CW]);
    end
    pos = '0;
    pos[idx] = 1'b1;
  end
endmodule

// File: rtl/walk_chain.sv
module walk_chain
  import wchain_pkg::*;
#(
  parameter int NSTAGES = 3,
  localparam int POSW   = (DIGITS - 1) * NSTAGES + 1
)(
  input  logic                      clk,
  input  logic                      rst_n,
  output logic [DIGITS*NSTAGES-1:0] stage_hot,
  output logic [CW*NSTAGES-1:0]     stage_cnt,
  output logic [POSW-1:0]           pos_hot,
  output logic                      seq_done
);
  logic [NSTAGES-1:0] at0, at9, adv, clr;

  for (genvar k = 0; k < NSTAGES; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign adv[k] = 1'b1;
      assign clr[k] = at9[NSTAGES-1];
    end else begin : g_tail
      assign adv[k] = at9[k-1];
      assign clr[k] = at0[k-1];

      assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !at9[k-1] && !at0[k-1] |=> $stable(stage_cnt[k*CW +: CW]));
    end

    decade_stage u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv[k]),
      .clr   (clr[k]),
      .cnt   (stage_cnt[k*CW +: CW]),
      .hot   (stage_hot[k*DIGITS +: DIGITS]),
      .at0   (at0[k]),
      .at9   (at9[k])
    );
  end

  pos_encoder #(.NST(NSTAGES)) u_pos (
    .cnts (stage_cnt),
    .pos  (pos_hot)
  );

  assign seq_done = at9[NSTAGES-1];

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (stage_cnt[CW-1:0] == '0));
  assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(pos_hot));
  assert_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_done) |-> (stage_cnt[CW-1:0] == count_t'(DIGITS - 1)));
endmodule

// File: tb/tb_walk_chain.sv
`timescale 1ns/1ps
module tb_walk_chain;
  localparam int N    = 3;
  localparam int P    = 10 * N;
  localparam int POSW = 9 * N + 1;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [10*N-1:0]     stage_hot;
  logic [4*N-1:0]      stage_cnt;
  logic [POSW-1:0]     pos_hot;
  logic                seq_done;
  int                  compared = 0;
  int                  mismatched = 0;

  always #2.5 clk = ~clk;

  walk_chain #(.NSTAGES(N)) dut (
    .clk(clk), .rst_n(rst_n), .stage_hot(stage_hot),
    .stage_cnt(stage_cnt), .pos_hot(pos_hot), .seq_done(seq_done)
  );

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_cnt(int k, int tm);
    int v;
    if (tm <= 9 * N) begin
      v = (k == 0) ? tm : tm - 9 * k;
      if (v < 0) v = 0;
      if (v > 9) v = 9;
      return v;
    end
    return (k < tm - 9 * N) ? 0 : 9;
  endfunction

  task automatic check_all(int tm, string tag);
    int posi;
    for (int k = 0; k < N; k++) begin
      string rq;
      if (tag != "") rq = tag;
      else if (k == 0) rq = (tm <= 9) ? "R2" : "R5 R2";
      else rq = (tm <= 9 * N) ? "R3 R4" : "R6";
      chk(rq, int'(stage_cnt[4*k +: 4]), exp_cnt(k, tm));
      chk((tag != "") ? tag : "R7", int'(stage_hot[10*k +: 10]), 1 << exp_cnt(k, tm));
    end
    posi = (tm < 9 * N) ? tm : 9 * N;
    chk((tag != "") ? tag : "R8", int'($countones(pos_hot)), 1);
    chk((tag != "") ? tag : "R8", int'(pos_hot[posi]), 1);
    chk((tag != "") ? tag : "R9", int'(seq_done), (tm >= 9 * N) ? 1 : 0);
  endtask

  initial begin
    #(200000 * 5);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1: reset state while held
    repeat (3) @(negedge clk);
    check_all(0, "R1");
    rst_n = 1'b1;
    check_all(0, "R1");
    // Three full cycles, every clock checked (R2..R9, period of R6)
    for (int i = 1; i <= 3 * P; i++) begin
      @(negedge clk);
      check_all(i % P, "");
    end
    // R10: reset in the middle of stage 1's walk
    for (int i = 1; i <= 14; i++) @(negedge clk);
    chk("R10 pre", int'(stage_cnt[7:4]), 5);
    rst_n = 1'b0;
    #1;
    check_all(0, "R10");
    @(negedge clk);
    check_all(0, "R10");
    rst_n = 1'b1;
    for (int i = 1; i <= P + 5; i++) begin
      @(negedge clk);
      check_all(i % P, "");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule